// File: doc/BRIEF.md
# Keyed-toggle watchdog timer

This block is a watchdog timer clocked by the bus clock. Software controls it through one 32-bit configuration word on a plain write strobe plus data bus, and a read bus that always shows the word's current contents. The low bits of the word hold a reload value, counted in units of 2^PRESCALE_W bus clocks (256 with the default parameters). Two 2-bit key fields in the word accept a two-write sequence: arm, then fire. A completed sequence in the enable key flips the timer between running and stopped. A completed sequence in the service key restarts the countdown from the reload value.

While the timer runs, a prescaler divides the bus clock and a down-counter steps once per prescaler wrap. When the counter runs out, the block raises `expire` for one clock. It then reloads the counter and keeps running, so `expire` repeats until software stops or services the timer. A read-only status bit at the top of the word shows whether the timer is running. The parameters must satisfy RELOAD_W + PRESCALE_W <= 32, so that the whole timeout in bus cycles fits in 32 bits, and RELOAD_W <= 24. Elaboration stops with an error otherwise.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, `rdData` reads all zeros (timer stopped, reload value zero), `expire` is low, and no key sequence is armed. A fire code written first therefore does nothing.
- R2: Every write stores `wrData[RELOAD_W-1:0]` as the reload value, whatever its key fields hold. From the next cycle it reads back on `rdData[RELOAD_W-1:0]`. `rdData[30:RELOAD_W]` reads zero.
- R3: `rdData[31]` reads 1 while the timer runs and 0 while it is stopped. A write that sets `wrData[31]` does not change it, and it changes only through a completed enable sequence.
- R4: The enable key is `wrData[25:24]`. A write with code 01 (arm) followed directly by a write with code 10 (fire) toggles the running state on the fire write's clock edge.
- R5: A key sequence completes only when the fire write directly follows an arm write to the same field. A write carrying any other code in that field (00, 11) drops the armed state. A fire code with nothing armed does nothing.
- R6: Starting the timer loads the counter from the reload value and clears the prescaler. The first `expire` is seen in the cycle after the clock edge that lies reload x 2^PRESCALE_W edges after the edge that starts the timer. A reload value of 0 acts as 1.
- R7: `expire` is high for exactly one clock. The counter then reloads and runs on, so the following expiries come every reload x 2^PRESCALE_W clocks.
- R8: The service key is `wrData[27:26]`, with the same arm (01) then fire (10) sequence. Completed while the timer runs, it restarts the full timeout from the fire write's edge.
- R9: While the timer is stopped, `expire` stays low, the counter and prescaler hold, and a completed service sequence neither starts the timer nor raises `expire`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrData | input | 32 | Write data: reload value, enable key, service key |
| rdData | output | 32 | Current configuration word with the running-status bit |
| expire | output | 1 | One-clock pulse when the countdown runs out |

## Verification
The bench builds the block with RELOAD_W = 24 and PRESCALE_W = 3, so one reload unit is 8 clocks rather than 256. With that setting it can time every expiry to the exact edge, across reload values 0, 1, 2, 5 and 9, and watch several periods in a row. The small prescaler also lets it check that a service partway through the countdown pushes expiry back by the full period, and that a broken service sequence leaves the countdown untouched. The same short window serves the long quiet stretches used to show that a stopped timer never raises `expire`.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  // Bit positions of the configuration word decoded by software.
  localparam int EN_KEY_LSB  = 24;
  localparam int SVC_KEY_LSB = 26;
  localparam int STATUS_BIT  = 31;
  localparam int WORD_W      = 32;

  // Two-step key codes.
  localparam logic [1:0] KEY_ARM  = 2'b01;
  localparam logic [1:0] KEY_FIRE = 2'b10;

  // Strobes from control to datapath.
  typedef struct packed {
    logic run;   // timer running: advance prescaler and counter
    logic load;  // restart countdown from reload value, clear prescaler
  } dp_ctl_t;
endpackage

// File: rtl/kwd_key_seq.sv
module kwd_key_seq
  import kwd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] keyField,
  output logic       fire
);
  logic armed;

  // Any write re-evaluates the armed state: only an arm code keeps it set.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (wrEn) begin
      armed <= (keyField == KEY_ARM);
    end
  end

  assign fire = wrEn && armed && (keyField == KEY_FIRE);
endmodule

// File: rtl/kwd_ctrl.sv
module kwd_ctrl
  import kwd_pkg::*;
#(
  parameter int RELOAD_W = 24
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WORD_W-1:0]   wrData,
  output logic [WORD_W-1:0]   rdData,
  output logic [RELOAD_W-1:0] reloadSel,
  output dp_ctl_t             dpCtl,
  output logic                enToggle
);
  localparam int NUM_KEYS = 2;
  localparam int PAD_W    = WORD_W - 1 - RELOAD_W;

  logic [RELOAD_W-1:0] reloadReg;
  logic                running;
  logic [NUM_KEYS-1:0] keyFire;
  logic                svcFire;
  logic [3:0]          unusedHi;

  // Key 0 is the enable key, key 1 the service key.
  for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
    localparam int LSB = (k == 0) ? EN_KEY_LSB : SVC_KEY_LSB;
    kwd_key_seq uKey (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (wrEn),
      .keyField(wrData[LSB+1:LSB]),
      .fire    (keyFire[k])
    );
  end

  assign enToggle = keyFire[0];
  assign svcFire  = keyFire[1];
  assign unusedHi = wrData[WORD_W-1:WORD_W-4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
      running   <= 1'b0;
    end else begin
      if (wrEn) begin
        reloadReg <= wrData[RELOAD_W-1:0];
      end
      if (enToggle) begin
        running <= ~running;
      end
    end
  end

  // The value the counter picks up this cycle matches what the register holds next.
  assign reloadSel = wrEn ? wrData[RELOAD_W-1:0] : reloadReg;

  always_comb begin
    dpCtl.run  = running;
    dpCtl.load = (enToggle && !running) || (svcFire && running && !enToggle);
  end

  assign rdData = {running, {PAD_W{1'b0}}, reloadReg};
endmodule

// File: rtl/kwd_datapath.sv
module kwd_datapath
  import kwd_pkg::*;
#(
  parameter int RELOAD_W   = 24,
  parameter int PRESCALE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_ctl_t             dpCtl,
  input  logic [RELOAD_W-1:0] reloadSel,
  output logic                expire
);
  localparam logic [PRESCALE_W-1:0] PRE_MAX = '1;
  localparam logic [RELOAD_W-1:0]   CNT_ONE = RELOAD_W'(1);

  logic [PRESCALE_W-1:0] preCnt;
  logic [RELOAD_W-1:0]   downCnt;
  logic                  tick;

  assign tick = dpCtl.run && (preCnt == PRE_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt  <= '0;
      downCnt <= '0;
      expire  <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (dpCtl.load) begin
        preCnt  <= '0;
        downCnt <= reloadSel;
      end else if (dpCtl.run) begin
        preCnt <= preCnt + 1'b1;
        if (tick) begin
          if (downCnt <= CNT_ONE) begin
            expire  <= 1'b1;
            downCnt <= reloadSel;
          end else begin
            downCnt <= downCnt - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import kwd_pkg::*;
#(
  parameter int RELOAD_W   = 24,
  parameter int PRESCALE_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        expire
);
  if ((RELOAD_W + PRESCALE_W > WORD_W) || (RELOAD_W > EN_KEY_LSB) || (PRESCALE_W < 1)) begin : g_bad_param
    $error("keyed_watchdog: timeout must fit 32 bits and reload must sit below the key fields");
  end

  dp_ctl_t             dpCtl;
  logic [RELOAD_W-1:0] reloadSel;
  logic                enToggle;

  kwd_ctrl #(.RELOAD_W(RELOAD_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrData   (wrData),
    .rdData   (rdData),
    .reloadSel(reloadSel),
    .dpCtl    (dpCtl),
    .enToggle (enToggle)
  );

  kwd_datapath #(.RELOAD_W(RELOAD_W), .PRESCALE_W(PRESCALE_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .dpCtl    (dpCtl),
    .reloadSel(reloadSel),
    .expire   (expire)
  );
endmodule

// File: rtl/kwd_chk.sv
module kwd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        wrEn,
  input logic [31:0] wrData,
  input logic [31:0] rdData,
  input logic        expire,
  input logic        enToggle
);
  // R7
  expire_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> !expire);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    expire |-> $past(rdData[31]));

  // R4
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    enToggle |=> (rdData[31] != $past(rdData[31])));

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enToggle |=> $stable(rdData[31]));

  // R2
  reload_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData[23:0] == $past(wrData[23:0])));
endmodule

bind keyed_watchdog kwd_chk uChk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .wrData  (wrData),
  .rdData  (rdData),
  .expire  (expire),
  .enToggle(enToggle)
);

// File: tb/sim_keyed_watchdog.sv
`timescale 1ns/1ps
module sim_keyed_watchdog;
  localparam int PW   = 3;
  localparam int UNIT = 1 << PW;
  localparam int NV   = 5;
  localparam logic [23:0] VEC_RELOAD [NV] = '{24'd1, 24'd2, 24'd5, 24'd0, 24'd9};
  localparam int          VEC_CYCLES [NV] = '{8, 16, 40, 8, 72};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        expire;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  keyed_watchdog #(.RELOAD_W(24), .PRESCALE_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .expire(expire)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Starts and ends at a negedge; the write lands on the posedge in between.
  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic [1:0] enKey, input logic [1:0] svcKey,
                                       input logic [23:0] rel);
    return {4'b0, svcKey, enKey, rel};
  endfunction

  task automatic toggleSeq(input logic [23:0] rel);
    wr(word(2'b01, 2'b00, rel));
    wr(word(2'b10, 2'b00, rel));
  endtask

  task automatic serviceSeq(input logic [23:0] rel);
    wr(word(2'b00, 2'b01, rel));
    wr(word(2'b00, 2'b10, rel));
  endtask

  // Edges counted from the last write edge until expire is seen; -1 if not within limit.
  task automatic measure(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (expire) begin
        n = i;
        break;
      end
    end
  endtask

  task automatic quiet(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (expire) seen++;
    end
  endtask

  initial begin
    int n;
    int seen;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(rdData == 32'h0, "R1 reset word", rdData, 0);
    check(expire == 1'b0, "R1 reset expire", expire, 0);
    // R1/R5 lone fire code after reset: nothing armed
    wr(word(2'b10, 2'b00, 24'd3));
    check(rdData[31] == 1'b0, "R1 lone fire after reset", rdData[31], 0);

    // Table walk: R2, R3, R4, R6, R7
    for (int v = 0; v < NV; v++) begin
      toggleSeq(VEC_RELOAD[v]);
      check(rdData[23:0] == VEC_RELOAD[v], "R2 reload readback", rdData[23:0], VEC_RELOAD[v]);
      check(rdData[31] == 1'b1, "R4 enable toggles on", rdData[31], 1);
      measure(200, n);
      check(n == VEC_CYCLES[v], "R6 first expiry delay", n, VEC_CYCLES[v]);
      @(posedge clk);
      @(negedge clk);
      check(expire == 1'b0, "R7 single-cycle pulse", expire, 0);
      measure(200, n);
      check(n == VEC_CYCLES[v] - 1, "R7 periodic expiry", n, VEC_CYCLES[v] - 1);
      toggleSeq(VEC_RELOAD[v]);
      check(rdData[31] == 1'b0, "R4 enable toggles off", rdData[31], 0);
    end

    // R3 status bit write is ignored; R2 upper bits read zero
    wr(32'h8000_0005);
    check(rdData == 32'h0000_0005, "R3 status write ignored", rdData, 32'h5);

    // R5 arm, then other code, then fire: no toggle
    wr(word(2'b01, 2'b00, 24'd2));
    wr(word(2'b00, 2'b00, 24'd2));
    wr(word(2'b10, 2'b00, 24'd2));
    check(rdData[31] == 1'b0, "R5 broken enable sequence", rdData[31], 0);
    wr(word(2'b01, 2'b00, 24'd2));
    wr(word(2'b11, 2'b00, 24'd2));
    wr(word(2'b10, 2'b00, 24'd2));
    check(rdData[31] == 1'b0, "R5 code 11 breaks sequence", rdData[31], 0);

    // R9 stopped: service sequence and long wait give no expiry
    serviceSeq(24'd1);
    check(rdData[31] == 1'b0, "R9 service while stopped", rdData[31], 0);
    quiet(100, seen);
    check(seen == 0, "R9 no expiry while stopped", seen, 0);

    // R8 service mid-count restarts full timeout
    toggleSeq(24'd4);
    quiet(20, seen);
    check(seen == 0, "R8 no early expiry", seen, 0);
    serviceSeq(24'd4);
    measure(200, n);
    check(n == 4 * UNIT, "R8 service restarts timeout", n, 4 * UNIT);

    // R5 broken service sequence leaves countdown running (reload 4 from last expiry edge)
    wr(word(2'b00, 2'b01, 24'd4));
    wr(word(2'b00, 2'b00, 24'd4));
    wr(word(2'b00, 2'b10, 24'd4));
    measure(200, n);
    check(n == 4 * UNIT - 3, "R5 broken service sequence", n, 4 * UNIT - 3);

    toggleSeq(24'd4);
    check(rdData[31] == 1'b0, "R4 final stop", rdData[31], 0);
    quiet(64, seen);
    check(seen == 0, "R9 quiet after stop", seen, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog timeout actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule